// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where a 32-bit RISC-V-style core fetches next after a control-transfer instruction. It is given the current program counter, a decoded transfer kind, the two source operand values, the branch comparison code and the raw instruction word. From the instruction bits it rebuilds the scattered branch, jump and register-jump offsets. It evaluates the branch condition and then produces the next PC, a taken flag, the return-address (link) value and a flag for a misaligned target.

Results are captured in one register stage under an input valid strobe, which acts as a clock enable. The reset input is asynchronous and active low. Its release is synchronised inside the block. Register reads, fetch and pipeline flushing belong to the surrounding core.

Top module: `nxpc_unit`

## Requirements
- R1: While reset is held, and for two clock edges after it is released, out_valid, next_pc, taken, link_val and misalign are all zero.
- R2: out_valid equals in_valid delayed by one clock. When in_valid is low, next_pc, taken, link_val and misalign keep their previous values.
- R3: When kind is 01 (branch), br_fn selects the condition on opa and opb: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. Codes 010 and 011 are never taken.
- R4: When kind is 00 (sequential), or when a branch is not taken, taken is 0 and next_pc is pc_in + 4.
- R5: A taken branch sets next_pc to pc_in plus a sign-extended 13-bit offset. The offset bits map from instr as follows: bit 12 from bit 31, bit 11 from bit 7, bits 10:5 from bits 30:25, bits 4:1 from bits 11:8, and bit 0 is zero.
- R6: When kind is 10 (jump-and-link), taken is 1 and next_pc is pc_in plus a sign-extended 21-bit offset. The offset bits map from instr as follows: bit 20 from bit 31, bits 19:12 from bits 19:12, bit 11 from bit 20, bits 10:1 from bits 30:21, and bit 0 is zero.
- R7: When kind is 11 (register jump), taken is 1 and next_pc is opa plus the sign-extended instr[31:20], with bit 0 of the sum forced to zero.
- R8: link_val is pc_in + 4 for every kind.
- R9: misalign is 1 exactly when taken is 1 and bit 1 of next_pc is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture enable for a new transfer |
| pc_in | input | 32 | PC of the current instruction |
| kind | input | 2 | Transfer kind: 00 sequential, 01 branch, 10 jump-and-link, 11 register jump |
| opa | input | 32 | First source operand (comparison input and jump base) |
| opb | input | 32 | Second source operand (comparison input) |
| br_fn | input | 3 | Branch comparison code |
| instr | input | 32 | Raw instruction word |
| out_valid | output | 1 | Registered results are new this cycle |
| next_pc | output | 32 | Address to fetch next |
| taken | output | 1 | Control transfer redirects the PC |
| link_val | output | 32 | Return address (pc_in + 4) |
| misalign | output | 1 | Taken target is not 4-byte aligned |

## Verification
Some properties are checked by the assertions on every cycle. These are the valid delay and the hold of the outputs when idle, the link value, the rule that illegal comparison codes and sequential kinds never redirect, and that jumps always redirect with bit 0 of a register-jump target clear. They also cover the tie between misalign, taken and bit 1 of the target. The assertions cannot show that the six comparisons give the right answer at signed and unsigned extremes, or that the scattered immediate bits are put back in the right places. Only the bench sweeps show these. They encode known offsets into instruction words and compare the targets with sums computed in the bench.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;
  typedef enum logic [1:0] {
    XFER_SEQ    = 2'b00,
    XFER_BRANCH = 2'b01,
    XFER_JAL    = 2'b10,
    XFER_JALR   = 2'b11
  } xfer_kind_e;

  localparam logic [2:0] CMP_EQ  = 3'b000;
  localparam logic [2:0] CMP_NE  = 3'b001;
  localparam logic [2:0] CMP_LT  = 3'b100;
  localparam logic [2:0] CMP_GE  = 3'b101;
  localparam logic [2:0] CMP_LTU = 3'b110;
  localparam logic [2:0] CMP_GEU = 3'b111;

  localparam int unsigned INSN_W = 32;
endpackage

// File: rtl/nxpc_imm_gen.sv
module nxpc_imm_gen
  import nxpc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [INSN_W-1:0] instr,
  output logic [XLEN-1:0]   b_off,
  output logic [XLEN-1:0]   j_off,
  output logic [XLEN-1:0]   i_off
);
  localparam int unsigned B_EXT = XLEN - 12;
  localparam int unsigned J_EXT = XLEN - 20;
  localparam int unsigned I_EXT = XLEN - 11;

  logic sgn;

  always_comb begin
    sgn   = instr[31];
    b_off = {{B_EXT{sgn}}, instr[7], instr[30:25], instr[11:8], 1'b0};
    j_off = {{J_EXT{sgn}}, instr[19:12], instr[20], instr[30:21], 1'b0};
    i_off = {{I_EXT{sgn}}, instr[30:20]};
  end
endmodule

// File: rtl/nxpc_cond_eval.sv
module nxpc_cond_eval
  import nxpc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [2:0]      br_fn,
  output logic            take
);
  localparam int unsigned EW = XLEN + 1;

  logic          signed_cmp;
  logic [EW-1:0] ext_a;
  logic [EW-1:0] ext_b;
  logic [EW-1:0] diff;
  logic          lt;
  logic          eq;

  always_comb begin
    signed_cmp = ~br_fn[1];
    ext_a      = {signed_cmp & opa[XLEN-1], opa};
    ext_b      = {signed_cmp & opb[XLEN-1], opb};
    diff       = ext_a - ext_b;
    lt         = diff[EW-1];
    eq         = (opa == opb);
    unique case (br_fn)
      CMP_EQ:          take = eq;
      CMP_NE:          take = ~eq;
      CMP_LT, CMP_LTU: take = lt;
      CMP_GE, CMP_GEU: take = ~lt;
      default:         take = 1'b0;
    endcase
  end
endmodule

// File: rtl/nxpc_target.sv
module nxpc_target
  import nxpc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [1:0]      kind,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] b_off,
  input  logic [XLEN-1:0] j_off,
  input  logic [XLEN-1:0] i_off,
  input  logic            cond,
  output logic [XLEN-1:0] nxt,
  output logic            redirect,
  output logic [XLEN-1:0] link
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_pc;
  logic [XLEN-1:0] jal_pc;
  logic [XLEN-1:0] jr_sum;

  always_comb begin
    seq_pc = pc_in + STEP;
    br_pc  = pc_in + b_off;
    jal_pc = pc_in + j_off;
    jr_sum = opa + i_off;
    link   = seq_pc;
    unique case (xfer_kind_e'(kind))
      XFER_BRANCH: begin
        redirect = cond;
        nxt      = cond ? br_pc : seq_pc;
      end
      XFER_JAL: begin
        redirect = 1'b1;
        nxt      = jal_pc;
      end
      XFER_JALR: begin
        redirect = 1'b1;
        nxt      = {jr_sum[XLEN-1:1], 1'b0};
      end
      default: begin
        redirect = 1'b0;
        nxt      = seq_pc;
      end
    endcase
  end
endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
  import nxpc_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] pc_in,
  input  logic [1:0]      kind,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [2:0]      br_fn,
  input  logic [31:0]     instr,
  output logic            out_valid,
  output logic [XLEN-1:0] next_pc,
  output logic            taken,
  output logic [XLEN-1:0] link_val,
  output logic            misalign
);
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_q = rst_pipe[RST_STAGES-1];

  logic [XLEN-1:0] b_off, j_off, i_off;
  logic            cond;
  logic [XLEN-1:0] nxt_c, link_c;
  logic            redir_c;

  nxpc_imm_gen #(.XLEN(XLEN)) u_imm (
    .instr(instr), .b_off(b_off), .j_off(j_off), .i_off(i_off)
  );

  nxpc_cond_eval #(.XLEN(XLEN)) u_cmp (
    .opa(opa), .opb(opb), .br_fn(br_fn), .take(cond)
  );

  nxpc_target #(.XLEN(XLEN)) u_tgt (
    .kind(kind), .pc_in(pc_in), .opa(opa), .b_off(b_off), .j_off(j_off),
    .i_off(i_off), .cond(cond), .nxt(nxt_c), .redirect(redir_c), .link(link_c)
  );

  logic            vld_d;
  logic [XLEN-1:0] npc_d, link_d;
  logic            tkn_d, mis_d;

  always_comb begin
    vld_d  = in_valid;
    npc_d  = next_pc;
    link_d = link_val;
    tkn_d  = taken;
    mis_d  = misalign;
    if (in_valid) begin
      npc_d  = nxt_c;
      link_d = link_c;
      tkn_d  = redir_c;
      mis_d  = redir_c & nxt_c[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      out_valid <= 1'b0;
      next_pc   <= '0;
      link_val  <= '0;
      taken     <= 1'b0;
      misalign  <= 1'b0;
    end else begin
      out_valid <= vld_d;
      next_pc   <= npc_d;
      link_val  <= link_d;
      taken     <= tkn_d;
      misalign  <= mis_d;
    end
  end
endmodule

// File: rtl/nxpc_unit_chk.sv
module nxpc_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [XLEN-1:0] pc_in,
  input logic [1:0]      kind,
  input logic [2:0]      br_fn,
  input logic            out_valid,
  input logic [XLEN-1:0] next_pc,
  input logic            taken,
  input logic [XLEN-1:0] link_val,
  input logic            misalign
);
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (!out_valid && !taken && !misalign &&
                                     next_pc == '0 && link_val == '0);
    end
  end

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(next_pc) && $stable(taken) && $stable(link_val) && $stable(misalign)));
  assert_illegal_fn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && kind == 2'b01 && br_fn[2:1] == 2'b01) |=> !taken);
  assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && kind == 2'b00) |=> (!taken && next_pc == $past(pc_in) + XLEN'(4)));
  assert_jal_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && kind == 2'b10) |=> taken);
  assert_jr_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && kind == 2'b11) |=> (taken && !next_pc[0]));
  assert_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> link_val == $past(pc_in) + XLEN'(4));
  assert_mis_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !taken) |-> !misalign);
  assert_mis_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && taken) |-> (misalign == next_pc[1]));
endmodule

bind nxpc_unit nxpc_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n_q), .in_valid(in_valid), .pc_in(pc_in), .kind(kind),
  .br_fn(br_fn), .out_valid(out_valid), .next_pc(next_pc), .taken(taken),
  .link_val(link_val), .misalign(misalign)
);

// File: tb/sim_nxpc_unit.sv
`timescale 1ns/1ps
module sim_nxpc_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] pc_in, opa, opb, instr;
  logic [1:0]  kind;
  logic [2:0]  br_fn;
  logic        out_valid, taken, misalign;
  logic [31:0] next_pc, link_val;
  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  nxpc_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc_in(pc_in), .kind(kind),
    .opa(opa), .opb(opb), .br_fn(br_fn), .instr(instr), .out_valid(out_valid),
    .next_pc(next_pc), .taken(taken), .link_val(link_val), .misalign(misalign)
  );

  function automatic logic [31:0] enc_b(input logic [12:0] off, input logic [2:0] fn);
    return {off[12], off[10:5], 5'd2, 5'd1, fn, off[4:1], off[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_j(input logic [20:0] off);
    return {off[20], off[10:1], off[11], off[19:12], 5'd1, 7'b1101111};
  endfunction
  function automatic logic [31:0] enc_i(input logic [11:0] imm);
    return {imm, 5'd1, 3'b000, 5'd1, 7'b1100111};
  endfunction

  function automatic logic cond_of(input logic [2:0] fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      3'b000:  return a == b;
      3'b001:  return a != b;
      3'b100:  return $signed(a) < $signed(b);
      3'b101:  return $signed(a) >= $signed(b);
      3'b110:  return a < b;
      3'b111:  return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run(input string req, input logic [31:0] pc, input logic [1:0] k,
                     input logic [31:0] a, input logic [31:0] b, input logic [2:0] fn,
                     input logic [31:0] ins, input logic [31:0] exp_pc, input logic exp_tk);
    logic exp_mis;
    @(negedge clk);
    in_valid = 1'b1; pc_in = pc; kind = k; opa = a; opb = b; br_fn = fn; instr = ins;
    @(posedge clk);
    @(negedge clk);
    exp_mis = exp_tk & exp_pc[1];
    total++;
    if (!out_valid || next_pc !== exp_pc || taken !== exp_tk ||
        link_val !== pc + 32'd4 || misalign !== exp_mis) begin
      bad++;
      $display("FAIL %s: got v=%b pc=%h tk=%b link=%h mis=%b exp v=1 pc=%h tk=%b link=%h mis=%b",
               req, out_valid, next_pc, taken, link_val, misalign,
               exp_pc, exp_tk, pc + 32'd4, exp_mis);
    end
  endtask

  initial begin : watchdog
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] vals [5];
    logic [12:0] boffs [6];
    logic [20:0] joffs [5];
    logic [11:0] ioffs [5];
    logic [31:0] hold_pc;
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'h7FFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF;
    boffs[0] = 13'h1000; boffs[1] = 13'h0FFE; boffs[2] = 13'h0002;
    boffs[3] = 13'h1FFE; boffs[4] = 13'h0008; boffs[5] = 13'h0800;
    joffs[0] = 21'h10_0000; joffs[1] = 21'h0F_FFFE; joffs[2] = 21'h00_0002;
    joffs[3] = 21'h00_0800; joffs[4] = 21'h1F_FFF8;
    ioffs[0] = 12'h800; ioffs[1] = 12'h7FF; ioffs[2] = 12'h000;
    ioffs[3] = 12'hFFF; ioffs[4] = 12'h006;

    rst_n = 1'b1; in_valid = 1'b0; pc_in = '0; kind = '0; opa = '0; opb = '0;
    br_fn = '0; instr = '0;
    #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (out_valid || taken || misalign || next_pc !== 0 || link_val !== 0) begin
      bad++;
      $display("FAIL R1: got v=%b pc=%h tk=%b link=%h mis=%b exp all zero",
               out_valid, next_pc, taken, link_val, misalign);
    end
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R3 R4 R5 R8 R9: every comparison code against signed/unsigned extremes
    for (int f = 0; f < 8; f++) begin
      for (int i = 0; i < 5; i++) begin
        for (int j = 0; j < 5; j++) begin
          logic [12:0] off;
          logic [31:0] pc, tgt;
          logic        c;
          off = boffs[(f + i + j) % 6];
          pc  = 32'h0000_4000 + 32'(f * 256 + i * 16 + j * 4);
          c   = cond_of(3'(f), vals[i], vals[j]);
          tgt = c ? pc + {{19{off[12]}}, off} : pc + 32'd4;
          run(c ? "R3_R5" : "R3_R4", pc, 2'b01, vals[i], vals[j], 3'(f),
              enc_b(off, 3'(f)), tgt, c);
        end
      end
    end

    // R4 sequential kind, including wrap of pc
    run("R4", 32'h0000_0100, 2'b00, 32'h5, 32'h5, 3'b000, enc_b(13'h0FFE, 3'b000), 32'h0000_0104, 1'b0);
    run("R4", 32'hFFFF_FFFC, 2'b00, 32'h0, 32'h0, 3'b000, 32'h0, 32'h0000_0000, 1'b0);

    // R6 jump-and-link offsets at both limits and with bit 11 / bit 1 set
    for (int n = 0; n < 5; n++) begin
      logic [31:0] pc;
      pc = 32'h0020_0000 + 32'(n * 4);
      run("R6", pc, 2'b10, 32'hDEAD_BEEF, 32'h0, 3'b010, enc_j(joffs[n]),
          pc + {{11{joffs[n][20]}}, joffs[n]}, 1'b1);
    end

    // R7 register jump: bit 0 cleared, immediates at limits, odd bases
    for (int n = 0; n < 5; n++) begin
      logic [31:0] base, sum;
      base = 32'h0001_0000 + 32'(n * 3);
      sum  = base + {{20{ioffs[n][11]}}, ioffs[n]};
      run("R7", 32'h0000_8000, 2'b11, base, 32'h0, 3'b000, enc_i(ioffs[n]),
          {sum[31:1], 1'b0}, 1'b1);
    end
    run("R7_R9", 32'h0, 2'b11, 32'h0000_0003, 32'h0, 3'b000, enc_i(12'h000), 32'h0000_0002, 1'b1);

    // R2: idle cycle keeps the last result while inputs change
    hold_pc = next_pc;
    @(negedge clk);
    in_valid = 1'b0; pc_in = 32'h1234_5678; kind = 2'b10; instr = enc_j(21'h00_0040);
    @(posedge clk);
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || next_pc !== hold_pc || taken !== 1'b1 ||
        link_val !== 32'h0000_0004 || misalign !== 1'b1) begin
      bad++;
      $display("FAIL R2: got v=%b pc=%h tk=%b link=%h mis=%b exp v=0 pc=%h tk=1 link=00000004 mis=1",
               out_valid, next_pc, taken, link_val, misalign, hold_pc);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule